// File: doc/BRIEF.md
# Integer Matrix-Vector Multiply Engine

This block multiplies a locally held signed 8-bit weight matrix of ROWS by COLS entries by a stream of signed 8-bit activation vectors. Each output row is the exact 32-bit dot product of one stored weight row with the incoming vector. The matrix stays in place and is reused for every vector. A fixed four-register pipeline accepts one vector per cycle. The pipeline stalls only when the result consumer holds off.

Weights are held in two banks. Compute reads the active bank. A single-entry write port fills the other bank, the shadow, and it never stalls the datapath. A swap pulse exchanges the roles of the two banks at the next clock edge. Because a whole vector is accepted in a single cycle, every vector sees exactly one bank.

A row-enable register selects which rows take part. The lane registers of a disabled row hold their value. The row reports zero with its row-valid flag low, so a partly used matrix costs little switching activity.

Top module: `mvm_engine`

## Requirements
- R1: For an enabled row r, the result equals the sum over c of W[r][c]*A[c], with every element read as signed two's-complement 8-bit and the sum kept exactly as signed 32-bit. Element c of `act_data` sits in bits [8c+7:8c], and row r of `res_data` sits in bits [32r+31:32r].
- R2: A vector is accepted on a clock edge where `act_valid` and `act_ready` are both high. Its result is presented with `res_valid` high after the third following edge. Back-to-back vectors are accepted one per cycle while the output is not stalled.
- R3: Each result is computed from the bank that was active on the edge where its vector was accepted.
- R4: A weight write always goes to the shadow bank. It has no effect on results until a swap makes that bank active.
- R5: A `bank_swap` pulse exchanges the active and shadow banks at its clock edge. A vector accepted on that same edge still uses the old active bank. A write on that same edge lands in the bank that becomes active.
- R6: A weight write whose row index is ROWS or more, or whose column index is COLS or more, is ignored and alters no stored weight. The row and column index ports are each one bit wider than the index needs.
- R7: `mask_wr` loads `mask_data` into the row-enable register (bit r enables row r), which affects vectors accepted after that edge. For a disabled row, `res_row_valid[r]` is low, its `res_data` slice is zero, and its lane registers keep their value.
- R8: While `res_valid` is high and `res_ready` is low, `act_ready` is low, no vector is accepted, and the result outputs hold steady. Otherwise `act_ready` is high.
- R9: Weight writes and swaps are accepted during an output stall. Results already in flight keep the weights they were accepted with.
- R10: After reset, `res_valid` and all row-valid flags are low, both banks hold zero, bank 0 is active, and every row is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | Activation vector offered |
| act_ready | output | 1 | Engine can take a vector this cycle |
| act_data | input | COLS*8 | Packed signed activation elements |
| wt_wr_en | input | 1 | Write one weight to the shadow bank |
| wt_row | input | clog2(ROWS)+1 | Row index of the weight write |
| wt_col | input | clog2(COLS)+1 | Column index of the weight write |
| wt_data | input | 8 | Signed weight value |
| bank_swap | input | 1 | Exchange active and shadow banks |
| mask_wr | input | 1 | Load the row-enable register |
| mask_data | input | ROWS | New row-enable bits |
| res_valid | output | 1 | A result vector is presented |
| res_ready | input | 1 | Consumer takes the result |
| res_row_valid | output | ROWS | Per-row flag: this row carries a result |
| res_data | output | ROWS*32 | Packed signed 32-bit row results |

## Verification
On every cycle the assertions check four things: a stalled result holds still, a disabled row reads zero with its flag low, a disabled row's output register does not move, and the engine is ready whenever no result is pending. Only the bench scenarios can show the arithmetic, the four-edge latency, and which bank each vector used. Those scenarios cover swaps on the acceptance edge, writes during a stall, and writes with out-of-range indices. The bench checks them against a behavioural model of both banks and the pipeline.

// File: rtl/mvm_pkg.sv
// Shared widths, types and arithmetic helpers for the matrix-vector engine.
// Assumes 8-bit signed operands and a 32-bit signed accumulator.
package mvm_pkg;
    localparam int OPW  = 8;
    localparam int PRDW = 2 * OPW;
    localparam int ACCW = 32;

    typedef logic signed [OPW-1:0]  elem_t;
    typedef logic signed [PRDW-1:0] prod_t;
    typedef logic signed [ACCW-1:0] acc_t;

    // Exact signed product of two 8-bit elements.
    function automatic prod_t mul8(input elem_t a, input elem_t b);
        prod_t ea;
        prod_t eb;
        ea = {{OPW{a[OPW-1]}}, a};
        eb = {{OPW{b[OPW-1]}}, b};
        return ea * eb;
    endfunction

    // Sign-extend a product to accumulator width.
    function automatic acc_t sext(input prod_t p);
        return {{(ACCW-PRDW){p[PRDW-1]}}, p};
    endfunction
endpackage

// File: rtl/mvm_weight_banks.sv
// Two weight banks: one active (read by compute), one shadow (written).
// A swap pulse exchanges them at the edge; a same-edge write lands in the
// bank being promoted. Writes with out-of-range indices are dropped.
module mvm_weight_banks
    import mvm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RSEL = $clog2(ROWS),
    localparam int CSEL = $clog2(COLS),
    localparam int RIW  = RSEL + 1,
    localparam int CIW  = CSEL + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RIW-1:0]           wr_row,
    input  logic [CIW-1:0]           wr_col,
    input  logic [OPW-1:0]           wr_data,
    input  logic                     swap,
    output logic [ROWS*COLS*OPW-1:0] active_w
);
    logic [OPW-1:0] bank0 [ROWS][COLS];
    logic [OPW-1:0] bank1 [ROWS][COLS];
    logic           sel;
    logic           in_range;

    assign in_range = (int'(wr_row) < ROWS) && (int'(wr_col) < COLS);

    // Track which bank is active.
    always_ff @(posedge clk) begin
        if (!rst_n) sel <= 1'b0;
        else if (swap) sel <= ~sel;
    end

    // Store writes into whichever bank is currently the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin
                    bank0[r][c] <= '0;
                    bank1[r][c] <= '0;
                end
        end else if (wr_en && in_range) begin
            if (sel) bank0[wr_row[RSEL-1:0]][wr_col[CSEL-1:0]] <= wr_data;
            else     bank1[wr_row[RSEL-1:0]][wr_col[CSEL-1:0]] <= wr_data;
        end
    end

    // Present the active bank flattened, row-major.
    always_comb begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                active_w[(r*COLS+c)*OPW +: OPW] = sel ? bank1[r][c] : bank0[r][c];
    end
endmodule

// File: rtl/mvm_row_lane.sv
// One output row: multiply stage, two adder-tree stages, output register.
// Each stage loads only on its enable, so a disabled row toggles nothing.
// Assumes COLS is a multiple of GRP.
module mvm_row_lane
    import mvm_pkg::*;
#(
    parameter int COLS = 8,
    parameter int GRP  = 4,
    localparam int NGRP = COLS / GRP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_mul,
    input  logic                en_grp,
    input  logic                en_tot,
    input  logic                en_out,
    input  logic [COLS*OPW-1:0] act_vec,
    input  logic [COLS*OPW-1:0] wt_vec,
    output acc_t                acc_q
);
    prod_t prod_q [COLS];
    acc_t  grp_d  [NGRP];
    acc_t  grp_q  [NGRP];
    acc_t  tot_d;
    acc_t  tot_q;

    // Stage 1: register element-wise products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) prod_q[c] <= '0;
        end else if (en_mul) begin
            for (int c = 0; c < COLS; c++)
                prod_q[c] <= mul8(act_vec[c*OPW +: OPW], wt_vec[c*OPW +: OPW]);
        end
    end

    // Tree level 1: sum each group of products.
    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            grp_d[g] = '0;
            for (int k = 0; k < GRP; k++) grp_d[g] = grp_d[g] + sext(prod_q[g*GRP+k]);
        end
    end

    // Stage 2: register the group sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NGRP; g++) grp_q[g] <= '0;
        end else if (en_grp) begin
            for (int g = 0; g < NGRP; g++) grp_q[g] <= grp_d[g];
        end
    end

    // Tree level 2: combine the group sums.
    always_comb begin
        tot_d = '0;
        for (int g = 0; g < NGRP; g++) tot_d = tot_d + grp_q[g];
    end

    // Stage 3: register the total.
    always_ff @(posedge clk) begin
        if (!rst_n)      tot_q <= '0;
        else if (en_tot) tot_q <= tot_d;
    end

    // Stage 4: output register.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (en_out) acc_q <= tot_q;
    end
endmodule

// File: rtl/mvm_engine.sv
// Matrix-vector engine top: weight banks, row-enable register, pipeline
// control and one lane per row. The whole pipe advances unless a presented
// result is not taken. Weight writes never depend on the pipeline state.
module mvm_engine
    import mvm_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int GRP  = 4,
    localparam int RIW = $clog2(ROWS) + 1,
    localparam int CIW = $clog2(COLS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    output logic                 act_ready,
    input  logic [COLS*OPW-1:0]  act_data,
    input  logic                 wt_wr_en,
    input  logic [RIW-1:0]       wt_row,
    input  logic [CIW-1:0]       wt_col,
    input  logic [OPW-1:0]       wt_data,
    input  logic                 bank_swap,
    input  logic                 mask_wr,
    input  logic [ROWS-1:0]      mask_data,
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [ROWS-1:0]      res_row_valid,
    output logic [ROWS*ACCW-1:0] res_data
);
    logic [ROWS*COLS*OPW-1:0] active_w;
    logic [ROWS-1:0]          row_mask;
    logic                     adv, fire;
    logic                     v1, v2, v3, vo;
    logic [ROWS-1:0]          m1, m2, m3, mo;
    logic [ROWS-1:0]          en1, en2, en3, en4;
    acc_t                     lane_acc [ROWS];
    logic [ROWS*ACCW-1:0]     lane_acc_flat;

    assign adv       = !(vo && !res_ready);
    assign fire      = act_valid && adv;
    assign act_ready = adv;

    mvm_weight_banks #(.ROWS(ROWS), .COLS(COLS)) u_banks (
        .clk(clk), .rst_n(rst_n), .wr_en(wt_wr_en), .wr_row(wt_row),
        .wr_col(wt_col), .wr_data(wt_data), .swap(bank_swap), .active_w(active_w)
    );

    // Row-enable register, all rows on after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_mask <= '1;
        else if (mask_wr) row_mask <= mask_data;
    end

    // Stage valid flags and row masks travelling with each vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {v1, v2, v3, vo} <= '0;
            {m1, m2, m3, mo} <= '0;
        end else if (adv) begin
            v1 <= fire;
            m1 <= fire ? row_mask : '0;
            v2 <= v1;  m2 <= m1;
            v3 <= v2;  m3 <= m2;
            vo <= v3;  mo <= m3;
        end
    end

    assign en1 = {ROWS{fire}} & row_mask;
    assign en2 = {ROWS{adv && v1}} & m1;
    assign en3 = {ROWS{adv && v2}} & m2;
    assign en4 = {ROWS{adv && v3}} & m3;

    for (genvar r = 0; r < ROWS; r++) begin : g_lane
        mvm_row_lane #(.COLS(COLS), .GRP(GRP)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .en_mul(en1[r]), .en_grp(en2[r]), .en_tot(en3[r]), .en_out(en4[r]),
            .act_vec(act_data),
            .wt_vec(active_w[r*COLS*OPW +: COLS*OPW]),
            .acc_q(lane_acc[r])
        );
        assign lane_acc_flat[r*ACCW +: ACCW] = lane_acc[r];
    end

    assign res_valid     = vo;
    assign res_row_valid = {ROWS{vo}} & mo;

    // Zero the slices of rows that carry no result.
    always_comb begin
        for (int r = 0; r < ROWS; r++)
            res_data[r*ACCW +: ACCW] = res_row_valid[r] ? lane_acc[r] : '0;
    end
endmodule

// File: rtl/mvm_engine_chk.sv
// Cycle-level properties of the engine's result stream and row gating.
// Attached to every mvm_engine instance by the bind at the end.
module mvm_engine_chk #(
    parameter int ROWS = 8,
    parameter int ACCW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 act_ready,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [ROWS-1:0]      res_row_valid,
    input logic [ROWS*ACCW-1:0] res_data,
    input logic [ROWS-1:0]      en4,
    input logic [ROWS*ACCW-1:0] lane_acc_flat
);
    // R8: a result not taken stays presented and unchanged.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_row_valid)));

    // R8: with nothing presented the engine takes input.
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> act_ready);

    // R7: row flags only accompany a presented result.
    assert_rowflag_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_row_valid != '0) |-> res_valid);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // R7: a row without a result reads zero.
        assert_zero_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !res_row_valid[r] |-> (res_data[r*ACCW +: ACCW] == '0));
        // R7: an output register that is not loaded keeps its value.
        assert_gated_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !en4[r] |=> $stable(lane_acc_flat[r*ACCW +: ACCW]));
    end
endmodule

bind mvm_engine mvm_engine_chk #(.ROWS(ROWS), .ACCW(mvm_pkg::ACCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .act_ready(act_ready), .res_valid(res_valid),
    .res_ready(res_ready), .res_row_valid(res_row_valid), .res_data(res_data),
    .en4(en4), .lane_acc_flat(lane_acc_flat)
);

// File: tb/mvm_engine_tb.sv
module mvm_engine_tb;
    localparam int ROWS = 8;
    localparam int COLS = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              act_valid = 1'b0;
    logic              act_ready;
    logic [COLS*8-1:0] act_data = '0;
    logic              wt_wr_en = 1'b0;
    logic [3:0]        wt_row = '0;
    logic [3:0]        wt_col = '0;
    logic [7:0]        wt_data = '0;
    logic              bank_swap = 1'b0;
    logic              mask_wr = 1'b0;
    logic [ROWS-1:0]   mask_data = '0;
    logic              res_valid;
    logic              res_ready = 1'b1;
    logic [ROWS-1:0]   res_row_valid;
    logic [ROWS*32-1:0] res_data;

    int    errs = 0;
    int    checks = 0;
    bit    done = 0;
    string phase = "R10 reset";

    always #4 clk = ~clk;

    mvm_engine #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ready(act_ready),
        .act_data(act_data), .wt_wr_en(wt_wr_en), .wt_row(wt_row), .wt_col(wt_col),
        .wt_data(wt_data), .bank_swap(bank_swap), .mask_wr(mask_wr),
        .mask_data(mask_data), .res_valid(res_valid), .res_ready(res_ready),
        .res_row_valid(res_row_valid), .res_data(res_data)
    );

    // Behavioural reference: both banks, select, mask and a 4-slot pipe.
    int       wb [2][ROWS][COLS];
    int       msel;
    bit [ROWS-1:0] mmask;
    bit       pv [4];
    int       pval [4][ROWS];
    bit [ROWS-1:0] pm [4];

    always @(posedge clk) begin
        bit adv, fire;
        int s;
        if (!rst_n) begin
            msel = 0; mmask = '1;
            for (int i = 0; i < 4; i++) begin pv[i] = 0; pm[i] = '0; end
            for (int b = 0; b < 2; b++)
                for (int r = 0; r < ROWS; r++)
                    for (int c = 0; c < COLS; c++) wb[b][r][c] = 0;
        end else begin
            adv  = !(pv[3] && !res_ready);
            fire = act_valid && adv;
            if (adv) begin
                for (int i = 3; i > 0; i--) begin
                    pv[i] = pv[i-1]; pm[i] = pm[i-1];
                    for (int r = 0; r < ROWS; r++) pval[i][r] = pval[i-1][r];
                end
                pv[0] = fire;
                pm[0] = fire ? mmask : '0;
                for (int r = 0; r < ROWS; r++) begin
                    s = 0;
                    for (int c = 0; c < COLS; c++)
                        s += wb[msel][r][c] * int'($signed(act_data[c*8 +: 8]));
                    pval[0][r] = s;
                end
            end
            if (wt_wr_en && wt_row < ROWS && wt_col < COLS)
                wb[1-msel][wt_row][wt_col] = int'($signed(wt_data));
            if (bank_swap) msel = 1 - msel;
            if (mask_wr) mmask = mask_data;
        end
    end

    // Compare every output against the reference away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (res_valid !== pv[3]) begin
                errs++;
                $display("FAIL R2 [%s] res_valid actual=%0b expected=%0b", phase, res_valid, pv[3]);
            end
            checks++;
            if (act_ready !== !(pv[3] && !res_ready)) begin
                errs++;
                $display("FAIL R8 [%s] act_ready actual=%0b expected=%0b", phase, act_ready, !(pv[3] && !res_ready));
            end
            for (int r = 0; r < ROWS; r++) begin
                bit ev;
                int ed;
                ev = pv[3] && pm[3][r];
                ed = ev ? pval[3][r] : 0;
                checks++;
                if (res_row_valid[r] !== ev) begin
                    errs++;
                    $display("FAIL R7 [%s] row %0d valid actual=%0b expected=%0b", phase, r, res_row_valid[r], ev);
                end
                checks++;
                if ($signed(res_data[r*32 +: 32]) !== ed) begin
                    errs++;
                    $display("FAIL R1 [%s] row %0d data actual=%0d expected=%0d", phase, r,
                             $signed(res_data[r*32 +: 32]), ed);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int r, input int c, input logic [7:0] v);
        wt_wr_en = 1; wt_row = 4'(r); wt_col = 4'(c); wt_data = v;
        tick();
        wt_wr_en = 0;
    endtask

    task automatic load_shadow(input int s);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                wr(r, c, 8'((r*37 + c*11 + s*53) % 256));
    endtask

    task automatic swap();
        bank_swap = 1; tick(); bank_swap = 0;
    endtask

    task automatic set_act(input int s);
        for (int c = 0; c < COLS; c++) act_data[c*8 +: 8] = 8'((c*29 + s*71 + 3) % 256);
    endtask

    task automatic stream(input int n, input int s);
        for (int i = 0; i < n; i++) begin
            act_valid = 1; set_act(s + i); tick();
        end
        act_valid = 0;
    endtask

    task automatic drain();
        res_ready = 1; act_valid = 0;
        repeat (6) tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [ROWS*32-1:0] held;
        repeat (3) tick();
        rst_n = 1;
        tick();
        check(res_valid == 0, "R10 res_valid after reset", res_valid, 0);
        check(res_row_valid == '0, "R10 row valid after reset", res_row_valid, 0);
        check(act_ready == 1, "R10 act_ready after reset", act_ready, 1);

        phase = "R10 zero banks, all rows enabled";
        stream(4, 1); drain();

        phase = "R4 shadow write not visible";
        load_shadow(1);
        stream(3, 5); drain();

        phase = "R1 R2 R3 back-to-back after swap";
        swap();
        stream(10, 9);
        drain();

        phase = "R2 latency";
        act_valid = 1; set_act(40); tick(); act_valid = 0;
        tick(); tick();
        check(res_valid == 0, "R2 not yet valid after three edges", res_valid, 0);
        tick();
        check(res_valid == 1, "R2 valid after fourth edge", res_valid, 1);
        drain();

        phase = "R1 extreme operands";
        for (int c = 0; c < COLS; c++) begin
            wr(0, c, 8'h80); wr(1, c, 8'h7f); wr(2, c, (c % 2) ? 8'h80 : 8'h7f);
        end
        swap();
        act_valid = 1; act_data = {COLS{8'h80}}; tick();
        act_data = {COLS{8'h7f}}; tick();
        act_valid = 0;
        repeat (2) tick();
        check($signed(res_data[0 +: 32]) == 32'sd131072 || !res_valid, "R1 row0 -128*-128 sum",
              $signed(res_data[0 +: 32]), 131072);
        drain();

        phase = "R5 swap and write on acceptance edge";
        load_shadow(2);
        act_valid = 1; set_act(60); bank_swap = 1;
        wt_wr_en = 1; wt_row = 4'd3; wt_col = 4'd4; wt_data = 8'h9c;
        tick();
        bank_swap = 0; wt_wr_en = 0; set_act(61);
        tick();
        act_valid = 0;
        drain();

        phase = "R6 out-of-range writes ignored";
        load_shadow(3);
        wr(8, 0, 8'h55); wr(9, 1, 8'h66); wr(1, 8, 8'h77); wr(15, 15, 8'h11); wr(0, 9, 8'h22);
        swap();
        stream(4, 70); drain();

        phase = "R7 partial row mask";
        mask_data = 8'b1010_0101; mask_wr = 1; act_valid = 1; set_act(80); tick();
        mask_wr = 0; set_act(81); tick();
        act_valid = 0;
        stream(3, 82); drain();
        phase = "R7 all rows disabled";
        mask_data = '0; mask_wr = 1; tick(); mask_wr = 0;
        stream(3, 90); drain();
        check(res_row_valid == '0 && res_data == '0, "R7 disabled rows idle", res_row_valid, 0);
        mask_data = '1; mask_wr = 1; tick(); mask_wr = 0;

        phase = "R8 R9 stall with background writes";
        res_ready = 0;
        stream(6, 100);
        check(act_ready == 0, "R8 act_ready low in stall", act_ready, 0);
        held = res_data;
        load_shadow(4);
        check(res_data == held, "R8 result held in stall", 0, 0);
        swap();
        check(res_valid == 1, "R9 result still presented", res_valid, 1);
        res_ready = 1;
        stream(5, 120);
        res_ready = 0; tick(); tick(); res_ready = 1;
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule